// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider

This block divides a fast input clock by a programmable mixed number made of an integer N and a two-digit decimal fraction. An integer counter produces one output pulse every N input clocks. Its output pulses step a chain of two decade rate multipliers, one for the tenths digit and one for the hundredths digit. Over every hundred output pulses, the chain emits as many pulses as the fraction's value in hundredths. Each emitted pulse is captured and then passed through one more register stage on the input clock. It then freezes the counter for a single input clock, so that one division cycle lasts N+1 clocks. The long-run average division ratio is therefore N plus the fraction.

The block is meant to sit in the feedback path of a frequency synthesiser loop. The loop filter averages the N and N+1 cycles into a steady non-integer ratio. The integer value and the two digits are held static while the block runs. They are changed under reset.

Top module: `frac_div_top`

## Requirements
- R1: `div_out` is high for exactly one input clock per division cycle. The number of input clocks between consecutive rising edges of `div_out` is always N or N+1.
- R2: With both fraction digits zero, every division cycle lasts exactly N input clocks and `swallow` never rises.
- R3: Over any 100 consecutive division cycles, the cycles total 100·N + 10·T + H input clocks, where T is the tenths digit and H is the hundredths digit. `swallow` is high for exactly 10·T + H input clocks in that span.
- R4: The tenths and hundredths pulse streams never fire on the same output pulse. Every fired pulse produces exactly one single-clock `swallow` assertion.
- R5: `swallow` is only ever high in the input clock that directly follows an input clock in which `div_out` was high. That held clock lengthens the division cycle which is then in progress.
- R6: A digit input holding a code from 10 to 15 acts exactly as the digit 9. For example, T=12 with H=15 behaves as .99.
- R7: An integer input of 0 or 1 acts as N=2. Values 2 to 15 are used as given (4-bit binary).
- R8: Synchronous active-high reset holds `div_out` and `swallow` low. It clears the counter, both decade stages and the pending swallow. The first `div_out` pulse after release appears on the N-th rising clock edge after the release.
- R9: With the hundredths digit zero, any 10 consecutive division cycles contain exactly T cycles of length N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_n | input | 4 | Integer divide value N, binary |
| frac_tenths | input | 4 | Tenths digit of the fraction, BCD |
| frac_hundredths | input | 4 | Hundredths digit of the fraction, BCD |
| div_out | output | 1 | Divided output, one input clock wide |
| swallow | output | 1 | High during the input clock in which the counter is held |

## Verification
The bench builds the block with its default parameters: a 4-bit integer field and a two-stage decade chain. With these values the full integer range 0 to 15 is reachable, including the clamped values 0 and 1. All sixteen digit codes can be driven, so the clamping of codes 10 to 15 is exercised. The shortest divide of 2 combined with the densest fraction .99 puts a hold in nearly every short cycle, which stresses the latency of the swallow path. The largest divide of 15 with .99 gives the longest 100-cycle window. Reset is also applied while a swallow is pending, to show that the pending hold is discarded.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;
    localparam int DECADE    = 10;
    localparam int DCNT_W    = $clog2(DECADE);

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [DCNT_W-1:0]  dcnt_t;

    // Output of one decade stage: its own pulse and its wrap to the next stage
    typedef struct packed {
        logic fire;
        logic carry;
    } stage_out_t;

    // Swallow path: captured request, then resynchronised copy that holds
    typedef struct packed {
        logic latched;
        logic synced;
    } swallow_st_t;

    // Codes above nine behave as nine
    function automatic bcd_t clamp_bcd(input bcd_t d);
        return (int'(d) > DIGIT_MAX) ? bcd_t'(DIGIT_MAX) : d;
    endfunction

    // Spreads d hits evenly over 'slots' positions; slot c hits when the
    // running product crosses a multiple of 'slots'
    function automatic logic spread_hit(input int c, input int d, input int slots);
        return (((c + 1) * d) / slots) != ((c * d) / slots);
    endfunction

endpackage

// File: rtl/frac_div_decade.sv
module frac_div_decade
    import frac_div_pkg::*;
#(
    parameter int PATTERN = DECADE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  bcd_t       digit,
    output stage_out_t out
);

    dcnt_t pos;
    localparam dcnt_t LAST = dcnt_t'(DECADE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST) ? '0 : pos + dcnt_t'(1);
        end
    end

    always_comb begin
        out.carry = step && (pos == LAST);
        out.fire  = step && (int'(pos) < PATTERN)
                    && spread_hit(int'(pos), int'(digit), PATTERN);
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(digit) <= DIGIT_MAX); // R6

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST); // R3

endmodule

// File: rtl/frac_div_ratemul.sv
module frac_div_ratemul
    import frac_div_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  bcd_t digits [STAGES],
    output logic fire
);

    logic [STAGES-1:0] fires;
    logic [STAGES-1:0] carries;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic       step_i;
        stage_out_t so;
        if (i == 0) begin : g_first
            assign step_i = tick;
        end else begin : g_next
            assign step_i = carries[i-1];
        end
        // Every stage but the last keeps its final slot free for the wrap
        frac_div_decade #(
            .PATTERN((i == STAGES - 1) ? DECADE : DECADE - 1)
        ) u_decade (
            .clk   (clk),
            .rst   (rst),
            .step  (step_i),
            .digit (digits[i]),
            .out   (so)
        );
        assign fires[i]   = so.fire;
        assign carries[i] = so.carry;
    end

    assign fire = |fires;

    AST_NO_COINCIDE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fires)); // R4

    if (STAGES >= 2) begin : g_chk
        AST_WRAP_CHAIN: assert property (@(posedge clk) disable iff (rst)
            carries[STAGES-1] |-> carries[STAGES-2]); // R3
    end

    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        fire |-> tick); // R4

endmodule

// File: rtl/frac_div_swallow.sv
module frac_div_swallow
    import frac_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic hold
);

    swallow_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (hold) begin
            st <= '0;
        end else begin
            st.synced <= st.latched;
            if (fire) begin
                st.latched <= 1'b1;
            end
        end
    end

    assign hold = st.synced;

    AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> !hold); // R4

    AST_FIRE_NOT_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |-> !fire); // R5

endmodule

// File: rtl/frac_div_counter.sv
module frac_div_counter #(
    parameter int N_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_eff,
    input  logic           hold,
    output logic           tc
);

    localparam logic [N_W-1:0] ONE = {{(N_W-1){1'b0}}, 1'b1};

    logic [N_W-1:0] count;
    logic           at_end;

    assign at_end = (count == n_eff - ONE);
    assign tc     = at_end && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!hold) begin
            count <= at_end ? '0 : count + ONE;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count <= n_eff - ONE); // R1

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(count)); // R5

endmodule

// File: rtl/frac_div_top.sv
module frac_div_top
    import frac_div_pkg::*;
#(
    parameter int N_W   = 4,
    parameter int N_MIN = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] div_n,
    input  logic [3:0]     frac_tenths,
    input  logic [3:0]     frac_hundredths,
    output logic           div_out,
    output logic           swallow
);

    localparam int STAGES = 2;
    localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

    logic [N_W-1:0] n_eff;
    bcd_t           digits [STAGES];
    logic           tc;
    logic           fire;
    logic           hold;

    assign n_eff     = (div_n < N_FLOOR) ? N_FLOOR : div_n;
    assign digits[0] = clamp_bcd(frac_tenths);
    assign digits[1] = clamp_bcd(frac_hundredths);

    frac_div_counter #(.N_W(N_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .n_eff (n_eff),
        .hold  (hold),
        .tc    (tc)
    );

    frac_div_ratemul #(.STAGES(STAGES)) u_ratemul (
        .clk    (clk),
        .rst    (rst),
        .tick   (tc),
        .digits (digits),
        .fire   (fire)
    );

    frac_div_swallow u_swallow (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .hold (hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
        end else begin
            div_out <= tc;
        end
    end

    assign swallow = hold;

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out); // R1

    AST_SWALLOW_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        swallow |-> $past(div_out)); // R5

    AST_N_FLOOR: assert property (@(posedge clk) disable iff (rst)
        n_eff >= N_FLOOR); // R7

endmodule

// File: tb/test_frac_div_top.sv
module test_frac_div_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div_n = 4'd8;
    logic [3:0] frac_tenths = 4'd0;
    logic [3:0] frac_hundredths = 4'd0;
    logic       div_out;
    logic       swallow;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    frac_div_top i_frac_div_top (
        .clk             (clk),
        .rst             (rst),
        .div_n           (div_n),
        .frac_tenths     (frac_tenths),
        .frac_hundredths (frac_hundredths),
        .div_out         (div_out),
        .swallow         (swallow)
    );

    // {n, tenths, hundredths, effective n, expected clocks per 100 cycles}
    localparam int NV = 10;
    localparam logic [31:0] VECS [0:NV-1] = '{
        {4'd8,  4'd5,  4'd7,  4'd8,  16'd857 },  // R3 main example
        {4'd2,  4'd0,  4'd0,  4'd2,  16'd200 },  // R2
        {4'd15, 4'd9,  4'd9,  4'd15, 16'd1599},  // R3
        {4'd3,  4'd0,  4'd1,  4'd3,  16'd301 },  // R3 hundredths only
        {4'd4,  4'd1,  4'd0,  4'd4,  16'd410 },  // R3 tenths only
        {4'd2,  4'd9,  4'd9,  4'd2,  16'd299 },  // R4 R5 dense
        {4'd7,  4'd12, 4'd3,  4'd7,  16'd793 },  // R6
        {4'd10, 4'd4,  4'd15, 4'd10, 16'd1049},  // R6
        {4'd0,  4'd15, 4'd15, 4'd2,  16'd299 },  // R7 R6
        {4'd1,  4'd3,  4'd5,  4'd2,  16'd235 }   // R7
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
            report();
        end
    end

    task automatic apply_reset(input logic [3:0] n, input logic [3:0] t, input logic [3:0] h);
        @(negedge clk);
        rst = 1'b1;
        div_n = n;
        frac_tenths = t;
        frac_hundredths = h;
        repeat (3) @(negedge clk);
    endtask

    // Releases reset and returns the edge number of the first pulse
    task automatic release_and_wait(output int edges);
        rst = 1'b0;
        edges = 0;
        do begin
            @(negedge clk);
            edges++;
        end while (!div_out && edges < 64);
    endtask

    task automatic measure(input int nper, output int total, output int minp,
                           output int maxp, output int swl, output int badw,
                           output int badl);
        int cnt = 0;
        int p = 0;
        logic prev_div = 1'b1;
        total = 0; minp = 1000; maxp = 0; swl = 0; badw = 0; badl = 0;
        while (p < nper) begin
            @(negedge clk);
            cnt++;
            if (swallow) swl++;
            if (swallow && !prev_div) badl++;
            if (div_out && prev_div) badw++;
            if (div_out) begin
                total += cnt;
                if (cnt < minp) minp = cnt;
                if (cnt > maxp) maxp = cnt;
                cnt = 0;
                p++;
            end
            prev_div = div_out;
        end
    endtask

    initial begin
        int edges, total, minp, maxp, swl, badw, badl;

        // R8: reset state and first pulse timing
        apply_reset(4'd6, 4'd5, 4'd0);
        check("R8 div_out in reset", int'(div_out), 0);
        check("R8 swallow in reset", int'(swallow), 0);
        release_and_wait(edges);
        check("R8 first pulse edge", edges, 6);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int neff, exp_tot, frac;
            neff    = int'(VECS[v][19:16]);
            exp_tot = int'(VECS[v][15:0]);
            frac    = exp_tot - 100 * neff;
            apply_reset(VECS[v][31:28], VECS[v][27:24], VECS[v][23:20]);
            release_and_wait(edges);
            check($sformatf("R8 R7 first pulse v%0d", v), edges, neff);
            measure(100, total, minp, maxp, swl, badw, badl);
            check($sformatf("R3 R6 R7 total v%0d", v), total, exp_tot);
            check($sformatf("R3 R4 swallow count v%0d", v), swl, frac);
            check($sformatf("R1 R2 min period v%0d", v), minp, neff);
            check($sformatf("R1 R2 max period v%0d", v), maxp, (frac > 0) ? neff + 1 : neff);
            check($sformatf("R1 pulse width v%0d", v), badw, 0);
            check($sformatf("R5 swallow latency v%0d", v), badl, 0);
        end

        // R9: tenths only, every window of 10 cycles holds T long cycles
        apply_reset(4'd4, 4'd3, 4'd0);
        release_and_wait(edges);
        for (int w = 0; w < 3; w++) begin
            measure(10, total, minp, maxp, swl, badw, badl);
            check($sformatf("R9 window %0d clocks", w), total, 43);
            check($sformatf("R9 window %0d swallows", w), swl, 3);
        end

        // R2: no swallow ever with zero fraction
        apply_reset(4'd9, 4'd0, 4'd0);
        release_and_wait(edges);
        measure(30, total, minp, maxp, swl, badw, badl);
        check("R2 zero fraction swallows", swl, 0);
        check("R2 zero fraction clocks", total, 270);

        // R8: reset with a swallow pending discards it
        apply_reset(4'd5, 4'd9, 4'd9);
        release_and_wait(edges);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 swallow cleared by reset", int'(swallow), 0);
        release_and_wait(edges);
        check("R8 first pulse after mid reset", edges, 5);

        report();
    end

endmodule